// File: doc/BRIEF.md
# I2C Bus Monitor with Optional Clock Stretch

This block listens to a two-wire I2C bus without taking part in it. It samples the clock and data lines on the system clock and recognises START, repeated START and STOP conditions. It shifts in every byte carried on the bus, including the address byte. Once the acknowledge bit has been seen, it copies the byte into a capture buffer, posts a status code and raises a service flag.

The status code reports two things: whether the byte was an address or data, and whether it belonged to a read or a write transfer. The read or write direction comes from the least significant bit of the address byte. The code also tells whether the ninth clock carried an ACK or a NACK.

Software reaches the block through a small register port: control, status, capture buffer and flag clear. When the stretch bit is set, the monitor holds SCL low after each byte until software clears the flag, so a slow handler loses nothing. The block has no SDA output at all.

Top module: `iic_monitor`

## Requirements
- R1: After reset the control register reads 0x00, the status reads 0xF8, the capture buffer reads 0x00, the service flag is low and the SCL hold output is low.
- R2: SDA is sampled on each rising SCL edge, most significant bit first. A falling SDA while SCL is high is a START, and it also acts as a repeated START inside a transfer. The first byte after any START is treated as the address byte, and its full eight bits, including the direction bit, land in the capture buffer.
- R3: For an address byte, the status depends on the direction bit and the acknowledge. Direction bit 1 (read) gives 0xA8 on ACK and 0x48 on NACK. Direction bit 0 (write) gives 0x60 on ACK and 0x20 on NACK. An ACK is SDA low during the ninth SCL high phase.
- R4: In a read transfer, a data byte posts 0xB8 when ACKed and 0xC0 when NACKed.
- R5: In a write transfer, a data byte posts 0x80 when ACKed and 0x88 when NACKed.
- R6: A rising SDA while SCL is high is a STOP, and it returns the monitor to idle. If the byte just before the STOP was an ACKed read-phase data byte, the status becomes 0xC8 and the flag is raised. Otherwise the status becomes 0xF8 and the flag is left unchanged.
- R7: Every completed byte loads the capture buffer, updates the status and sets the flag. Writing register 3 with bit 3 set clears the flag. Writing register 3 with bit 3 clear leaves the flag set.
- R8: With control bit 1 (stretch) and bit 0 (enable) set, the first SCL falling edge after a byte asserts the SCL hold output. The hold stays asserted until the flag is cleared, and it is released on the clock edge that clears the flag.
- R9: While control bit 1 is clear, the SCL hold output never asserts, so the monitor does not disturb the bus.
- R10: While control bit 0 (enable) is clear, bus traffic is ignored: the flag, status and capture buffer do not change.
- R11: The registers are selected by reg_addr_i. Register 0 is control, read/write, bits [1:0]. Register 1 is the status code, read-only. Register 2 is the capture buffer, read-only. Register 3 is the flag clear, write-only, and it reads 0x00. Read data is combinational from the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Observed bus clock line |
| sda_i | input | 1 | Observed bus data line |
| scl_hold_o | output | 1 | When high, an open-drain pad pulls SCL low |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| flag_o | output | 1 | Service flag, high when a byte or event awaits software |

## Verification
The bench sweeps addresses of both directions with every mix of address and data acknowledge. After each step it checks the status, the buffer and the flag, which catches a swapped code table or direction taken from the wrong bit.

A repeated START between a write and a read must re-enter address decoding. A design that kept the old direction would post write codes for the read.

The STOP that follows an ACKed read byte must post 0xC8. A STOP that follows a NACKed byte must post 0xF8. A monitor that ignored the last acknowledge would mix these up.

In stretch mode the hold must wait for SCL to fall and then persist until the clear. A design that held early, released early, or held with stretch disabled would either stall the bench master or show up in the hold monitor.

// File: rtl/iicmon_pkg.sv
package iicmon_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [7:0] {
        MS_IDLE     = 8'hF8,
        MS_AW_ACK   = 8'h60,
        MS_AW_NAK   = 8'h20,
        MS_AR_ACK   = 8'hA8,
        MS_AR_NAK   = 8'h48,
        MS_RD_ACK   = 8'hB8,
        MS_RD_NAK   = 8'hC0,
        MS_RD_LAST  = 8'hC8,
        MS_WD_ACK   = 8'h80,
        MS_WD_NAK   = 8'h88
    } mon_code_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
        logic              acked;
        logic              is_addr;
        logic              rd_phase;
    } byte_evt_t;

    localparam logic [REG_AW-1:0] RA_CTL    = 2'd0;
    localparam logic [REG_AW-1:0] RA_STATUS = 2'd1;
    localparam logic [REG_AW-1:0] RA_BUF    = 2'd2;
    localparam logic [REG_AW-1:0] RA_CLR    = 2'd3;

    localparam int unsigned CTL_EN_BIT      = 0;
    localparam int unsigned CTL_STRETCH_BIT = 1;
    localparam int unsigned CLR_FLAG_BIT    = 3;

endpackage

// File: rtl/iicmon_sync.sv
module iicmon_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t s_d, s_q;

    logic scl_now, sda_now;

    always_comb begin
        s_d        = s_q;
        s_d.scl_sh = {s_q.scl_sh[STAGES-2:0], scl_in};
        s_d.sda_sh = {s_q.sda_sh[STAGES-2:0], sda_in};
        s_d.scl_p  = s_q.scl_sh[STAGES-1];
        s_d.sda_p  = s_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_now = s_q.scl_sh[STAGES-1];
    assign sda_now = s_q.sda_sh[STAGES-1];
    assign sda_o   = sda_now;
    assign start_o = scl_now & s_q.scl_p & s_q.sda_p & ~sda_now;
    assign stop_o  = scl_now & s_q.scl_p & ~s_q.sda_p & sda_now;
    assign rise_o  = scl_now & ~s_q.scl_p;
    assign fall_o  = ~scl_now & s_q.scl_p;

    a_r2_start_not_stop: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !stop_o);

endmodule

// File: rtl/iicmon_shift.sv
module iicmon_shift
    import iicmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      start_i,
    input  logic      stop_i,
    input  logic      rise_i,
    input  logic      sda_i,
    output byte_evt_t bev_o,
    output logic      start_seen_o,
    output logic      stop_seen_o
);
    localparam int unsigned CW = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic              active;
        logic              first;
        logic              rd;
        logic [CW-1:0]     bitcnt;
        logic [BYTE_W-1:0] sh;
    } shf_t;

    shf_t f_d, f_q;
    byte_evt_t bev_d;

    always_comb begin
        f_d   = f_q;
        bev_d = '0;
        if (!en_i) begin
            f_d.active = 1'b0;
            f_d.bitcnt = '0;
        end else if (start_i) begin
            f_d.active = 1'b1;
            f_d.first  = 1'b1;
            f_d.bitcnt = '0;
        end else if (stop_i) begin
            f_d.active = 1'b0;
            f_d.bitcnt = '0;
        end else if (rise_i && f_q.active) begin
            if (f_q.bitcnt < CW'(BYTE_W)) begin
                f_d.sh     = {f_q.sh[BYTE_W-2:0], sda_i};
                f_d.bitcnt = f_q.bitcnt + CW'(1);
            end else begin
                bev_d.valid    = 1'b1;
                bev_d.data     = f_q.sh;
                bev_d.acked    = ~sda_i;
                bev_d.is_addr  = f_q.first;
                bev_d.rd_phase = f_q.first ? f_q.sh[0] : f_q.rd;
                if (f_q.first) f_d.rd = f_q.sh[0];
                f_d.first  = 1'b0;
                f_d.bitcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign bev_o        = bev_d;
    assign start_seen_o = en_i & start_i;
    assign stop_seen_o  = en_i & stop_i;

    a_r2_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.bitcnt <= CW'(BYTE_W));
    a_r2_addr_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && start_i) |=> (f_q.first && f_q.bitcnt == '0));
    a_r10_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !f_q.active);

endmodule

// File: rtl/iicmon_regs.sv
module iicmon_regs
    import iicmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  byte_evt_t         bev_i,
    input  logic              start_seen_i,
    input  logic              stop_seen_i,
    input  logic              fall_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              en_o,
    output logic              flag_o,
    output logic              hold_o
);
    typedef struct packed {
        logic [1:0]        ctl;
        logic [7:0]        status;
        logic [BYTE_W-1:0] capbuf;
        logic              flag;
        logic              hold;
        logic              last_rd_ack;
    } rf_t;

    rf_t r_d, r_q;
    logic clr_hit;
    logic [7:0] code;
    logic unused_wbits;

    assign unused_wbits = ^{reg_wdata_i[7:4], reg_wdata_i[2]};

    always_comb begin
        if (bev_i.is_addr) begin
            if (bev_i.rd_phase) code = bev_i.acked ? MS_AR_ACK : MS_AR_NAK;
            else                code = bev_i.acked ? MS_AW_ACK : MS_AW_NAK;
        end else begin
            if (bev_i.rd_phase) code = bev_i.acked ? MS_RD_ACK : MS_RD_NAK;
            else                code = bev_i.acked ? MS_WD_ACK : MS_WD_NAK;
        end
    end

    assign clr_hit = reg_wr_i && (reg_addr_i == RA_CLR) && reg_wdata_i[CLR_FLAG_BIT];

    always_comb begin
        r_d = r_q;
        if (reg_wr_i && reg_addr_i == RA_CTL) r_d.ctl = reg_wdata_i[1:0];
        if (clr_hit) r_d.flag = 1'b0;
        if (bev_i.valid) begin
            r_d.capbuf      = bev_i.data;
            r_d.status      = code;
            r_d.flag        = 1'b1;
            r_d.last_rd_ack = bev_i.rd_phase & ~bev_i.is_addr & bev_i.acked;
        end else if (stop_seen_i) begin
            r_d.status      = r_q.last_rd_ack ? MS_RD_LAST : MS_IDLE;
            if (r_q.last_rd_ack) r_d.flag = 1'b1;
            r_d.last_rd_ack = 1'b0;
        end else if (start_seen_i) begin
            r_d.last_rd_ack = 1'b0;
        end
        r_d.hold = r_d.flag & r_d.ctl[CTL_STRETCH_BIT] & r_d.ctl[CTL_EN_BIT]
                 & (r_q.hold | fall_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.status <= MS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr_i)
            RA_CTL:    reg_rdata_o = {6'd0, r_q.ctl};
            RA_STATUS: reg_rdata_o = r_q.status;
            RA_BUF:    reg_rdata_o = r_q.capbuf;
            default:   reg_rdata_o = 8'd0;
        endcase
    end

    assign en_o   = r_q.ctl[CTL_EN_BIT];
    assign flag_o = r_q.flag;
    assign hold_o = r_q.hold;

    a_r7_byte_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bev_i.valid |=> r_q.flag);
    a_r7_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !bev_i.valid && !stop_seen_i) |=> !r_q.flag);
    a_r8_hold_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.hold |-> r_q.flag);
    a_r9_no_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!r_q.ctl[CTL_STRETCH_BIT]) |-> !r_q.hold);
    a_r6_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen_i && !bev_i.valid) |=> (r_q.status == MS_IDLE || r_q.status == MS_RD_LAST));
    a_r10_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ctl[CTL_EN_BIT] |=> $stable(r_q.capbuf));

endmodule

// File: rtl/iic_monitor.sv
module iic_monitor
    import iicmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_hold_o,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    output logic [7:0]        reg_rdata_o,
    output logic              flag_o
);
    logic sda_s, ev_start, ev_stop, ev_rise, ev_fall;
    logic en, start_seen, stop_seen;
    byte_evt_t bev;

    iicmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_in  (scl_i),
        .sda_in  (sda_i),
        .sda_o   (sda_s),
        .start_o (ev_start),
        .stop_o  (ev_stop),
        .rise_o  (ev_rise),
        .fall_o  (ev_fall)
    );

    iicmon_shift u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en),
        .start_i      (ev_start),
        .stop_i       (ev_stop),
        .rise_i       (ev_rise),
        .sda_i        (sda_s),
        .bev_o        (bev),
        .start_seen_o (start_seen),
        .stop_seen_o  (stop_seen)
    );

    iicmon_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bev_i        (bev),
        .start_seen_i (start_seen),
        .stop_seen_i  (stop_seen),
        .fall_i       (ev_fall),
        .reg_addr_i   (reg_addr_i),
        .reg_wr_i     (reg_wr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .en_o         (en),
        .flag_o       (flag_o),
        .hold_o       (scl_hold_o)
    );

endmodule

// File: tb/sim_iic_monitor.sv
`timescale 1ns/1ps
module sim_iic_monitor;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic bus_scl;
    logic scl_hold;
    logic [1:0] reg_addr = 2'd0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic flag;

    int total = 0;
    int bad = 0;
    bit stretch_on = 1'b0;
    int hold_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign bus_scl = m_scl & ~scl_hold;

    iic_monitor u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (bus_scl),
        .sda_i       (m_sda),
        .scl_hold_o  (scl_hold),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .flag_o      (flag)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_scl_high();
        while (!bus_scl) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic bus_bit(logic b);
        m_sda = b; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(2 * Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(logic [7:0] v, bit ack);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        bus_bit(!ack);
    endtask

    function automatic int exp_code(bit is_addr, bit rd, bit ack);
        if (is_addr) return rd ? (ack ? 'hA8 : 'h48) : (ack ? 'h60 : 'h20);
        return rd ? (ack ? 'hB8 : 'hC0) : (ack ? 'h80 : 'h88);
    endfunction

    always @(negedge clk) if (rst_n && !stretch_on && scl_hold) hold_bad++;

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        logic [7:0] keep_buf, keep_st;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state, R11 map
        reg_read(2'd0, v); check("R1 ctl", v, 'h00);
        reg_read(2'd1, v); check("R1 status", v, 'hF8);
        reg_read(2'd2, v); check("R1 buffer", v, 'h00);
        check("R1 flag", flag, 0);
        check("R1 hold", scl_hold, 0);
        reg_read(2'd3, v); check("R11 clear reads zero", v, 'h00);
        reg_write(2'd0, 8'h03);
        reg_read(2'd0, v); check("R11 ctl readback", v, 'h03);
        reg_write(2'd0, 8'h01);

        // sweep R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < 32; i++) begin
            logic [7:0] a8, d8;
            bit aa, da, rd;
            a8 = 8'((i * 37 + 5) & 255);
            d8 = 8'((i * 53 + 11) & 255);
            aa = ((i >> 1) & 1) == 0;
            da = ((i >> 2) & 1) == 0;
            rd = a8[0];
            bus_start();
            send_byte(a8, aa);
            check("R7 flag after address", flag, 1);
            reg_read(2'd2, v); check("R2 address in buffer", v, a8);
            reg_read(2'd1, v); check("R3 address status", v, exp_code(1, rd, aa));
            reg_write(2'd3, 8'h08);
            check("R7 flag cleared", flag, 0);
            send_byte(d8, da);
            reg_read(2'd2, v); check("R7 data in buffer", v, d8);
            reg_read(2'd1, v);
            if (rd) check("R4 read data status", v, exp_code(0, 1, da));
            else    check("R5 write data status", v, exp_code(0, 0, da));
            reg_write(2'd3, 8'h08);
            bus_stop();
            reg_read(2'd1, v); check("R6 stop status", v, (rd && da) ? 'hC8 : 'hF8);
            check("R6 stop flag", flag, (rd && da) ? 1 : 0);
            reg_write(2'd3, 8'h08);
        end
        check("R9 no hold with stretch off", hold_bad, 0);

        // R7 clear with bit3 zero
        bus_start();
        send_byte(8'h90, 1);
        reg_write(2'd3, 8'hF7);
        check("R7 clear without bit3 keeps flag", flag, 1);
        reg_write(2'd3, 8'h08);
        bus_stop();

        // R2 repeated START
        bus_start();
        send_byte(8'h40, 1);
        reg_read(2'd1, v); check("R3 write address", v, 'h60);
        send_byte(8'h11, 1);
        reg_read(2'd1, v); check("R5 write data ack", v, 'h80);
        bus_start();
        send_byte(8'h41, 1);
        reg_read(2'd1, v); check("R2 repeated start read address", v, 'hA8);
        reg_read(2'd2, v); check("R2 repeated start buffer", v, 'h41);
        send_byte(8'h22, 0);
        reg_read(2'd1, v); check("R4 read data nack", v, 'hC0);
        reg_write(2'd3, 8'h08);
        bus_stop();
        reg_read(2'd1, v); check("R6 stop after nack", v, 'hF8);
        check("R6 flag stays low", flag, 0);

        // R10 disabled
        reg_read(2'd2, keep_buf);
        reg_read(2'd1, keep_st);
        reg_write(2'd0, 8'h00);
        bus_start();
        send_byte(8'h5A, 1);
        send_byte(8'h3C, 1);
        bus_stop();
        check("R10 flag while disabled", flag, 0);
        reg_read(2'd2, v); check("R10 buffer while disabled", v, keep_buf);
        reg_read(2'd1, v); check("R10 status while disabled", v, keep_st);

        // R8 stretch
        stretch_on = 1'b1;
        reg_write(2'd0, 8'h03);
        bus_start();
        send_byte(8'hA3, 1);
        check("R8 hold after byte", scl_hold, 1);
        check("R8 bus clock held low", bus_scl, 0);
        tick(60);
        check("R8 hold persists", scl_hold, 1);
        reg_read(2'd2, v); check("R8 buffer under stretch", v, 'hA3);
        reg_write(2'd3, 8'h08);
        check("R8 hold released", scl_hold, 0);
        send_byte(8'h7E, 0);
        check("R8 hold after second byte", scl_hold, 1);
        reg_read(2'd1, v); check("R4 stretched read nack", v, 'hC0);
        reg_write(2'd3, 8'h08);
        check("R8 hold released again", scl_hold, 0);
        bus_stop();
        reg_write(2'd0, 8'h01);
        stretch_on = 1'b0;
        tick(4);
        check("R9 hold off after disabling stretch", scl_hold, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule